// File: doc/BRIEF.md
# Occupancy Counter Motion Classifier

This block sits in the cell stream of a grid-based occupancy tracker. For every grid cell it takes two history counters, one counting past frames in which the cell was seen free and one counting frames in which it was seen occupied. It also takes the occupancy probability observed for the cell in the current frame. It accepts one cell per clock with no stalls. One cycle later it returns a motion mask bit and the two counters after this frame's update, ready to be written back to the history store.

Each probability is placed in one of three bands by two programmable thresholds: occupied, free, or undecided. An occupied observation adds one to the occupied counter. A free observation adds one to the free counter. An undecided observation leaves both counters as they were. Both counters stop at their largest value instead of wrapping.

A cell is marked dynamic when it is observed occupied now and its history was mostly empty. "Mostly empty" is tested without a divider: the free count must be at least K times (occupied count + 1), where K is a programmable integer. Only dynamic cells go on to the costly velocity update downstream. Static cells get their velocity hypotheses reset to uniform there. To let that stage size its work, the block counts the dynamic cells of each frame and reports the total once the frame's last cell has gone through.

Top module: `occ_motion_classifier`

The block has a small tally state machine with three states:
- T_IDLE: no cell of the current frame seen yet.
- T_ACCUM: cells of the frame are being counted.
- T_REPORT: a one-cycle report of the finished frame.

Its transitions are:
- stage-valid cell without the last flag: to T_ACCUM.
- stage-valid cell with the last flag: to T_REPORT, from any state.
- no stage-valid cell while in T_REPORT: to T_IDLE.
- no stage-valid cell in T_IDLE or T_ACCUM: stay in the same state.

## Requirements
- R1: While reset (rst_n low, active low, synchronous) is held and right after it, out_valid, out_dynamic and frame_done are 0 and frame_dyn_count is 0.
- R2: A cell accepted with in_valid high at a clock edge produces out_valid high after the next edge, one result per cell, back to back. A cycle with no cell gives out_valid 0 and out_dynamic 0.
- R3: An observation is occupied when in_prob > cfg_hi_thr (strictly). For such a cell, out_occ_cnt is in_occ_cnt + 1 and out_free_cnt equals in_free_cnt.
- R4: An observation is free when it is not occupied and in_prob < cfg_lo_thr (strictly). For such a cell, out_free_cnt is in_free_cnt + 1 and out_occ_cnt equals in_occ_cnt.
- R5: A probability in neither band, including one exactly equal to a threshold, leaves both counters unchanged at the output. At most one counter changes per cell.
- R6: Each counter saturates at 2^HC_W - 1 (255 by default). An increment at that value leaves it at that value.
- R7: out_dynamic is 1 exactly when the observation is occupied and in_free_cnt >= cfg_ratio_k * (in_occ_cnt + 1). The test uses the counts before this frame's update.
- R8: With cfg_ratio_k = 0, every occupied observation is dynamic, including one whose free count is 0.
- R9: When the cell carrying in_last leaves the block (out_valid high), frame_done pulses high for one cycle on the following cycle. At that point frame_dyn_count holds the number of dynamic cells output since the previous frame end. The value is held until the next report.
- R10: The cell after a frame's last cell starts a new tally from zero, even when it follows with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A cell is presented this cycle |
| in_last | input | 1 | The presented cell is the last of its frame |
| in_free_cnt | input | HC_W | Free-history count of the cell |
| in_occ_cnt | input | HC_W | Occupied-history count of the cell |
| in_prob | input | P_W | Observed occupancy probability, unsigned fraction |
| cfg_hi_thr | input | P_W | Probability above which the cell counts as occupied |
| cfg_lo_thr | input | P_W | Probability below which the cell counts as free |
| cfg_ratio_k | input | K_W | Ratio factor K of the mostly-empty test |
| out_valid | output | 1 | Result of a cell is present |
| out_dynamic | output | 1 | Motion mask bit of the cell |
| out_free_cnt | output | HC_W | Updated free-history count |
| out_occ_cnt | output | HC_W | Updated occupied-history count |
| frame_done | output | 1 | One-cycle pulse: frame tally is ready |
| frame_dyn_count | output | CNT_W | Dynamic cells in the last finished frame |

## Verification
The hardest situation to reach is the ratio test at its exact boundary while a counter is pinned at its ceiling. If the product K*(occ+1) is computed too narrowly, it wraps and can falsely declare a saturated cell dynamic. The stimulus table therefore places a cell with both counters at 255 and an occupied observation next to cells sitting exactly on the K*(occ+1) boundary. Tally framing is checked by starting a second frame directly after a last cell with no gap, with K set to zero.

// File: rtl/omc_pkg.sv
package omc_pkg;

    typedef enum logic [1:0] {
        OBS_UNK  = 2'd0,
        OBS_FREE = 2'd1,
        OBS_OCC  = 2'd2
    } obs_e;

    typedef enum logic [1:0] {
        T_IDLE   = 2'd0,
        T_ACCUM  = 2'd1,
        T_REPORT = 2'd2
    } tally_e;

endpackage

// File: rtl/omc_obs_quant.sv
module omc_obs_quant
    import omc_pkg::*;
#(
    parameter int P_W = 8
) (
    input  logic [P_W-1:0] prob,
    input  logic [P_W-1:0] hi_thr,
    input  logic [P_W-1:0] lo_thr,
    output obs_e           obs
);
    // Occupied band wins if the two bands were ever programmed to overlap.
    always_comb begin
        if (prob > hi_thr) begin
            obs = OBS_OCC;
        end else if (prob < lo_thr) begin
            obs = OBS_FREE;
        end else begin
            obs = OBS_UNK;
        end
    end
endmodule

// File: rtl/omc_hist_update.sv
module omc_hist_update
    import omc_pkg::*;
#(
    parameter int HC_W = 8
) (
    input  obs_e            obs,
    input  logic [HC_W-1:0] free_in,
    input  logic [HC_W-1:0] occ_in,
    output logic [HC_W-1:0] free_out,
    output logic [HC_W-1:0] occ_out
);
    localparam logic [HC_W-1:0] CNT_MAX = {HC_W{1'b1}};

    always_comb begin
        free_out = free_in;
        occ_out  = occ_in;
        unique case (obs)
            OBS_OCC:  if (occ_in != CNT_MAX)  occ_out  = occ_in + 1'b1;
            OBS_FREE: if (free_in != CNT_MAX) free_out = free_in + 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/omc_ratio_test.sv
module omc_ratio_test #(
    parameter int HC_W = 8,
    parameter int K_W  = 4
) (
    input  logic [HC_W-1:0] free_in,
    input  logic [HC_W-1:0] occ_in,
    input  logic [K_W-1:0]  ratio_k,
    output logic            mostly_free
);
    // Full-width product: K * (occ + 1) never wraps.
    localparam int PROD_W = HC_W + 1 + K_W;

    logic [PROD_W-1:0] occ_plus;
    logic [PROD_W-1:0] k_ext;
    logic [PROD_W-1:0] bound;

    always_comb begin
        occ_plus    = PROD_W'(occ_in) + PROD_W'(1);
        k_ext       = PROD_W'(ratio_k);
        bound       = k_ext * occ_plus;
        mostly_free = PROD_W'(free_in) >= bound;
    end
endmodule

// File: rtl/omc_tally.sv
module omc_tally
    import omc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cell_valid,
    input  logic             cell_last,
    input  logic             cell_dyn,
    output logic             done,
    output logic [CNT_W-1:0] dyn_count
);
    tally_e state_q, state_d;
    logic [CNT_W-1:0] acc_q;
    logic [CNT_W-1:0] acc_inc;

    assign acc_inc = acc_q + CNT_W'(cell_dyn);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T_IDLE, T_ACCUM: begin
                if (cell_valid && cell_last)  state_d = T_REPORT;
                else if (cell_valid)          state_d = T_ACCUM;
            end
            T_REPORT: begin
                if (cell_valid && cell_last)  state_d = T_REPORT;
                else if (cell_valid)          state_d = T_ACCUM;
                else                          state_d = T_IDLE;
            end
            default: state_d = T_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= T_IDLE;
        else        state_q <= state_d;
    end

    // Output and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            dyn_count <= '0;
        end else if (cell_valid) begin
            if (cell_last) begin
                dyn_count <= acc_inc;
                acc_q     <= '0;
            end else begin
                acc_q     <= acc_inc;
            end
        end
    end

    assign done = (state_q == T_REPORT);
endmodule

// File: rtl/occ_motion_classifier.sv
module occ_motion_classifier
    import omc_pkg::*;
#(
    parameter int HC_W      = 8,
    parameter int P_W       = 8,
    parameter int K_W       = 4,
    parameter int MAX_CELLS = 38400,
    localparam int CNT_W    = $clog2(MAX_CELLS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic [HC_W-1:0]  in_free_cnt,
    input  logic [HC_W-1:0]  in_occ_cnt,
    input  logic [P_W-1:0]   in_prob,
    input  logic [P_W-1:0]   cfg_hi_thr,
    input  logic [P_W-1:0]   cfg_lo_thr,
    input  logic [K_W-1:0]   cfg_ratio_k,
    output logic             out_valid,
    output logic             out_dynamic,
    output logic [HC_W-1:0]  out_free_cnt,
    output logic [HC_W-1:0]  out_occ_cnt,
    output logic             frame_done,
    output logic [CNT_W-1:0] frame_dyn_count
);
    obs_e            obs;
    logic [HC_W-1:0] free_nx;
    logic [HC_W-1:0] occ_nx;
    logic            mostly_free;
    logic            dyn_nx;
    logic            s1_last;

    omc_obs_quant #(.P_W(P_W)) quant_i (
        .prob   (in_prob),
        .hi_thr (cfg_hi_thr),
        .lo_thr (cfg_lo_thr),
        .obs    (obs)
    );

    omc_hist_update #(.HC_W(HC_W)) hist_i (
        .obs      (obs),
        .free_in  (in_free_cnt),
        .occ_in   (in_occ_cnt),
        .free_out (free_nx),
        .occ_out  (occ_nx)
    );

    omc_ratio_test #(.HC_W(HC_W), .K_W(K_W)) ratio_i (
        .free_in     (in_free_cnt),
        .occ_in      (in_occ_cnt),
        .ratio_k     (cfg_ratio_k),
        .mostly_free (mostly_free)
    );

    assign dyn_nx = (obs == OBS_OCC) && mostly_free;

    // Single result stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_dynamic  <= 1'b0;
            s1_last      <= 1'b0;
            out_free_cnt <= '0;
            out_occ_cnt  <= '0;
        end else begin
            out_valid    <= in_valid;
            out_dynamic  <= in_valid && dyn_nx;
            s1_last      <= in_valid && in_last;
            if (in_valid) begin
                out_free_cnt <= free_nx;
                out_occ_cnt  <= occ_nx;
            end
        end
    end

    omc_tally #(.CNT_W(CNT_W)) tally_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cell_valid (out_valid),
        .cell_last  (s1_last),
        .cell_dyn   (out_dynamic),
        .done       (frame_done),
        .dyn_count  (frame_dyn_count)
    );
endmodule

// File: rtl/omc_checker.sv
module omc_checker #(
    parameter int HC_W = 8,
    parameter int P_W  = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [HC_W-1:0] in_free_cnt,
    input logic [HC_W-1:0] in_occ_cnt,
    input logic [P_W-1:0]  in_prob,
    input logic [P_W-1:0]  cfg_hi_thr,
    input logic            out_valid,
    input logic            out_dynamic,
    input logic [HC_W-1:0] out_free_cnt,
    input logic [HC_W-1:0] out_occ_cnt,
    input logic            stage_last,
    input logic            frame_done
);
    a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_dynamic);

    a_r5_single_change: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !((out_free_cnt != $past(in_free_cnt)) &&
                        (out_occ_cnt  != $past(in_occ_cnt))));

    a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_free_cnt >= $past(in_free_cnt)) &&
                      (out_occ_cnt  >= $past(in_occ_cnt)));

    a_r7_dyn_needs_occ: assert property (@(posedge clk) disable iff (!rst_n)
        out_dynamic |-> ($past(in_prob) > $past(cfg_hi_thr)));

    a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(out_valid && stage_last));
endmodule

bind occ_motion_classifier omc_checker #(.HC_W(HC_W), .P_W(P_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_free_cnt  (in_free_cnt),
    .in_occ_cnt   (in_occ_cnt),
    .in_prob      (in_prob),
    .cfg_hi_thr   (cfg_hi_thr),
    .out_valid    (out_valid),
    .out_dynamic  (out_dynamic),
    .out_free_cnt (out_free_cnt),
    .out_occ_cnt  (out_occ_cnt),
    .stage_last   (s1_last),
    .frame_done   (frame_done)
);

// File: tb/occ_motion_classifier_tb.sv
module occ_motion_classifier_tb_top;
    localparam int HC_W  = 8;
    localparam int P_W   = 8;
    localparam int K_W   = 4;
    localparam int CNT_W = 16;
    localparam int NVEC  = 12;

    typedef struct packed {
        logic [7:0] f;
        logic [7:0] o;
        logic [7:0] p;
        logic       d;
        logic [7:0] ef;
        logic [7:0] eo;
    } vec_t;

    // hi=200, lo=50, K=2
    localparam vec_t VEC [NVEC] = '{
        '{8'd10,  8'd2,   8'd220, 1'b1, 8'd10,  8'd3},   // R7 R3
        '{8'd5,   8'd2,   8'd220, 1'b0, 8'd5,   8'd3},   // R7 below ratio
        '{8'd6,   8'd2,   8'd201, 1'b1, 8'd6,   8'd3},   // R7 boundary
        '{8'd6,   8'd2,   8'd200, 1'b0, 8'd6,   8'd2},   // R5 at hi
        '{8'd6,   8'd2,   8'd49,  1'b0, 8'd7,   8'd2},   // R4
        '{8'd6,   8'd2,   8'd50,  1'b0, 8'd6,   8'd2},   // R5 at lo
        '{8'd255, 8'd0,   8'd10,  1'b0, 8'd255, 8'd0},   // R6 free
        '{8'd255, 8'd255, 8'd250, 1'b0, 8'd255, 8'd255}, // R6 occ, wide product
        '{8'd100, 8'd0,   8'd255, 1'b1, 8'd100, 8'd1},   // R7
        '{8'd0,   8'd0,   8'd255, 1'b0, 8'd0,   8'd1},   // R3 not dynamic
        '{8'd40,  8'd9,   8'd230, 1'b1, 8'd40,  8'd10},  // R7
        '{8'd3,   8'd1,   8'd0,   1'b0, 8'd4,   8'd1}    // R4
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_last = 1'b0;
    logic [HC_W-1:0]  in_free_cnt = '0;
    logic [HC_W-1:0]  in_occ_cnt = '0;
    logic [P_W-1:0]   in_prob = '0;
    logic [P_W-1:0]   cfg_hi_thr = 8'd200;
    logic [P_W-1:0]   cfg_lo_thr = 8'd50;
    logic [K_W-1:0]   cfg_ratio_k = 4'd2;
    logic             out_valid;
    logic             out_dynamic;
    logic [HC_W-1:0]  out_free_cnt;
    logic [HC_W-1:0]  out_occ_cnt;
    logic             frame_done;
    logic [CNT_W-1:0] frame_dyn_count;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;   // 250 MHz

    occ_motion_classifier dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
        .in_free_cnt(in_free_cnt), .in_occ_cnt(in_occ_cnt), .in_prob(in_prob),
        .cfg_hi_thr(cfg_hi_thr), .cfg_lo_thr(cfg_lo_thr), .cfg_ratio_k(cfg_ratio_k),
        .out_valid(out_valid), .out_dynamic(out_dynamic),
        .out_free_cnt(out_free_cnt), .out_occ_cnt(out_occ_cnt),
        .frame_done(frame_done), .frame_dyn_count(frame_dyn_count)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic l, input logic [7:0] f,
                         input logic [7:0] o, input logic [7:0] p);
        in_valid = v; in_last = l; in_free_cnt = f; in_occ_cnt = o; in_prob = p;
    endtask

    initial begin
        #150000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid in reset", int'(out_valid), 0);
        check("R1 done in reset", int'(frame_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", int'(out_valid), 0);
        check("R1 dynamic after reset", int'(out_dynamic), 0);
        check("R1 count after reset", int'(frame_dyn_count), 0);

        // Frame A: table walked back to back
        for (int i = 0; i <= NVEC; i++) begin
            if (i > 0) begin
                check("R2 valid", int'(out_valid), 1);
                check("R7 dynamic", int'(out_dynamic), int'(VEC[i-1].d));
                check("R3 R4 R5 R6 free", int'(out_free_cnt), int'(VEC[i-1].ef));
                check("R3 R4 R5 R6 occ", int'(out_occ_cnt), int'(VEC[i-1].eo));
                check("R9 no early done", int'(frame_done), 0);
            end
            if (i < NVEC)
                drive(1'b1, i == NVEC - 1, VEC[i].f, VEC[i].o, VEC[i].p);
            else
                drive(1'b0, 1'b0, 8'd0, 8'd0, 8'd0);
            @(negedge clk);
        end
        check("R9 done pulse", int'(frame_done), 1);
        check("R9 frame count", int'(frame_dyn_count), 4);
        check("R2 idle valid", int'(out_valid), 0);
        check("R2 idle dynamic", int'(out_dynamic), 0);
        @(negedge clk);
        check("R9 done one cycle", int'(frame_done), 0);
        check("R9 count held", int'(frame_dyn_count), 4);

        // Frame B with K=0, then frame C directly after its last cell
        cfg_ratio_k = 4'd0;
        drive(1'b1, 1'b0, 8'd0, 8'd5, 8'd210);
        @(negedge clk);
        check("R8 K zero dynamic", int'(out_dynamic), 1);
        check("R8 K zero occ", int'(out_occ_cnt), 6);
        drive(1'b1, 1'b0, 8'd0, 8'd0, 8'd100);
        @(negedge clk);
        check("R8 unk not dynamic", int'(out_dynamic), 0);
        drive(1'b1, 1'b1, 8'd9, 8'd0, 8'd0);
        @(negedge clk);
        check("R8 free not dynamic", int'(out_dynamic), 0);
        check("R4 free inc", int'(out_free_cnt), 10);
        drive(1'b1, 1'b1, 8'd0, 8'd0, 8'd201);   // frame C, single cell
        @(negedge clk);
        check("R10 first of next dynamic", int'(out_dynamic), 1);
        check("R9 frame B done", int'(frame_done), 1);
        check("R9 frame B count", int'(frame_dyn_count), 1);
        drive(1'b0, 1'b0, 8'd0, 8'd0, 8'd0);
        @(negedge clk);
        check("R10 frame C done", int'(frame_done), 1);
        check("R10 frame C count", int'(frame_dyn_count), 1);
        @(negedge clk);
        check("R10 done drops", int'(frame_done), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule